// File: doc/BRIEF.md
# Seven-Bit-Address Serial Bus Slave Receiver

This block is the receive half of a slave on a two-wire serial bus (I2C) that uses 7-bit addressing. It oversamples the clock and data lines with a faster system clock and finds start and stop conditions. After a start it collects the first byte, compares its upper seven bits with a configured address and, on a hit, acknowledges by pulling the data line low. It then accepts data bytes from the master and acknowledges each one. A slave transmit phase, 10-bit addressing, clock stretching and general call are not part of the block.

Every accepted byte, the matched address byte included, goes into a one-entry receive buffer. The CPU reads this buffer through a read port and a read strobe. Each completed byte of an addressed transfer raises a one-cycle interrupt pulse. Status outputs give buffer-full, a sticky overflow flag, the direction bit of the last address and whether the buffered byte was data or address. If a byte completes while the buffer is still unread, the block keeps the old contents, sets overflow and withholds the acknowledge.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset `full_o`, `ovf_o`, `irq_o` and `sda_oe_o` are all 0.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Bytes clocked after a stop and before the next start produce no acknowledge, no interrupt and no buffer change.
- R3: The first byte after a start carries the address in bits 7..1 and the direction in bit 0, sent MSB first on SCL rising edges. The slave acknowledges it (SDA held low through the 9th SCL high phase) only when bits 7..1 equal `own_addr_i` and the buffer can take the byte.
- R4: On an address hit the whole address byte is loaded into the buffer. `full_o` becomes 1, `data_nadr_o` becomes 0 and `rnw_o` takes bit 0 of the byte.
- R5: On an address miss the slave gives no acknowledge and no interrupt, and the buffer is unchanged. It ignores later bytes until the next start.
- R6: In a write transfer each data byte is acknowledged when the buffer is free. The byte is loaded into the buffer with `full_o` = 1 and `data_nadr_o` = 1.
- R7: `irq_o` pulses high for exactly one clock for every completed byte of an addressed transfer, overflowed bytes included.
- R8: A byte that completes while the buffer is full sets `ovf_o` and leaves `rd_data_o` unchanged. The byte is not acknowledged. This holds for address and data bytes.
- R9: A one-cycle `rd_stb_i` clears `full_o`. `ovf_o` stays 1 until `ovf_clr_i` is pulsed.
- R10: SDA is driven only through the active-low enable `sda_oe_o` (1 pulls low). The enable changes only while the synchronized SCL is low, and it is released after the 9th clock.
- R11: A repeated start in the middle of a transfer restarts the address phase.
- R12: An address hit with bit 0 = 1 is acknowledged and recorded with `rnw_o` = 1. The clocks that follow are ignored until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pin |
| sda_i | input | 1 | Serial data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| own_addr_i | input | 7 | Configured slave address |
| rd_stb_i | input | 1 | CPU read strobe, clears buffer-full |
| rd_data_o | output | 8 | Receive buffer contents |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| irq_o | output | 1 | One-cycle pulse per completed byte |
| full_o | output | 1 | Buffer holds an unread byte |
| ovf_o | output | 1 | Sticky overflow flag |
| rnw_o | output | 1 | Direction bit of the last accepted address |
| data_nadr_o | output | 1 | 1 when the buffered byte is data, 0 when address |

## Verification
Most internal faults appear on the bus within one byte. A wrong bit count or a bad address comparison moves or drops the low level on SDA during the 9th clock, and the master sees this at that clock. A buffer flag stuck in the wrong state turns a later acknowledge into a missing one and raises overflow on the very next byte. The interrupt pulse and the buffer contents show a lost or doubled shift within the byte's own acknowledge window.

// File: rtl/i2c_rx_pkg.sv
// Shared types for the serial bus slave receiver.
// Assumes bytes are eight bits and addresses are seven bits wide.
package i2c_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W);

    // Link-level states of the receive sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK_SETUP,
        ST_ACK_HOLD,
        ST_SKIP
    } rx_state_t;

    // One completed byte handed from the sequencer to the buffer.
    typedef struct packed {
        logic              valid;
        logic              is_data;
        logic [BYTE_W-1:0] val;
    } rx_evt_t;
endpackage

// File: rtl/i2c_rx_sync.sv
// Two-wire line synchronizer and bus event detector.
// Brings SCL and SDA into the clock domain through a STAGES-deep chain and
// flags SCL edges and start/stop conditions. Lines reset to the idle-high level.
module i2c_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int CHAIN_W = 2 * STAGES;

    logic [CHAIN_W-1:0] chain;
    logic               scl_q, sda_q;

    // Shift both lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[CHAIN_W-3:0], scl_i, sda_i};
    end

    assign scl_s = chain[CHAIN_W-1];
    assign sda_s = chain[CHAIN_W-2];

    // Hold the previous synchronized values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_q;
    assign scl_fall  = ~scl_s &  scl_q;
    assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
    assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_rx_link.sv
// Receive sequencer: shifts bits on SCL rising edges, matches the address,
// reports completed bytes and drives the acknowledge through an active-low
// enable that only moves on SCL falling edges. Assumes no clock stretching.
module i2c_rx_link
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              buf_busy,
    output rx_evt_t           evt,
    output logic              sda_oe
);
    rx_state_t         state, after_ack;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_byte;
    logic              ack_q;
    logic              last_bit, addr_hit, in_rx;

    assign next_byte = {shreg[BYTE_W-2:0], sda_s};
    assign addr_hit  = next_byte[BYTE_W-1 -: ADDR_W] == own_addr;
    assign last_bit  = scl_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign in_rx     = (state == ST_ADDR) || (state == ST_DATA);

    // Report a completed byte only when it belongs to an addressed transfer.
    always_comb begin
        evt.valid   = last_bit && !start_det && !stop_det &&
                      ((state == ST_DATA) || (state == ST_ADDR && addr_hit));
        evt.is_data = (state == ST_DATA);
        evt.val     = next_byte;
    end

    // Sequence the bus phases and drive the acknowledge enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            ack_q     <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise) begin
                        shreg <= next_byte;
                        if (last_bit) begin
                            bit_cnt <= '0;
                            ack_q   <= !buf_busy;
                            if (state == ST_DATA) begin
                                after_ack <= ST_DATA;
                                state     <= ST_ACK_SETUP;
                            end else if (addr_hit) begin
                                after_ack <= next_byte[0] ? ST_SKIP : ST_DATA;
                                state     <= ST_ACK_SETUP;
                            end else begin
                                state     <= ST_SKIP;
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_ACK_SETUP: begin
                    if (scl_fall) begin
                        sda_oe <= ack_q;
                        state  <= ST_ACK_HOLD;
                    end
                end
                ST_ACK_HOLD: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= after_ack;
                    end
                end
                default: ;
            endcase
        end
    end

    logic unused_in_rx;
    assign unused_in_rx = in_rx;
endmodule

// File: rtl/i2c_rx_status.sv
// Single-entry receive buffer with interrupt pulse and status flags.
// A byte is accepted when the buffer is empty or being read in the same cycle;
// otherwise the sticky overflow flag is set and the old contents stay.
module i2c_rx_status
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  rx_evt_t           evt,
    input  logic              rd_stb,
    input  logic              ovf_clr,
    output logic              buf_busy,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq,
    output logic              full,
    output logic              ovf,
    output logic              rnw,
    output logic              is_data
);
    assign buf_busy = full & ~rd_stb;

    // Load, free and flag the receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            irq     <= 1'b0;
            full    <= 1'b0;
            ovf     <= 1'b0;
            rnw     <= 1'b0;
            is_data <= 1'b0;
        end else begin
            irq <= evt.valid;
            if (evt.valid && !buf_busy) begin
                rd_data <= evt.val;
                full    <= 1'b1;
                is_data <= evt.is_data;
                if (!evt.is_data) rnw <= evt.val[0];
            end else if (rd_stb) begin
                full <= 1'b0;
            end
            if (evt.valid && buf_busy) ovf <= 1'b1;
            else if (ovf_clr)          ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_rx_slave.sv
// Top of the serial bus slave receiver: synchronizer, receive sequencer and
// receive buffer. Assumes clk is at least eight times faster than SCL.
module i2c_rx_slave
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              rd_stb_i,
    output logic [BYTE_W-1:0] rd_data_o,
    input  logic              ovf_clr_i,
    output logic              irq_o,
    output logic              full_o,
    output logic              ovf_o,
    output logic              rnw_o,
    output logic              data_nadr_o
);
    logic    scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic    buf_busy;
    rx_evt_t evt;
    logic    byte_seen;

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rx_link i_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_addr  (own_addr_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .buf_busy  (buf_busy),
        .evt       (evt),
        .sda_oe    (sda_oe_o)
    );

    i2c_rx_status i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .rd_stb   (rd_stb_i),
        .ovf_clr  (ovf_clr_i),
        .buf_busy (buf_busy),
        .rd_data  (rd_data_o),
        .irq      (irq_o),
        .full     (full_o),
        .ovf      (ovf_o),
        .rnw      (rnw_o),
        .is_data  (data_nadr_o)
    );

    assign byte_seen = evt.valid;
endmodule

// File: rtl/i2c_rx_chk.sv
// Property checker for the slave receiver, bound to the top module.
module i2c_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe_o,
    input logic ovf_o,
    input logic ovf_clr_i,
    input logic irq_o,
    input logic full_o,
    input logic rd_stb_i,
    input logic byte_seen
);
    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);                    // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);                              // R9
    AST_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !byte_seen) |=> !full_o);                         // R9
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);                                             // R7
    AST_IRQ_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> full_o);                                             // R7
    AST_NO_ACK_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> !sda_oe_o);                                   // R8
endmodule

bind i2c_rx_slave i2c_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe_o  (sda_oe_o),
    .ovf_o     (ovf_o),
    .ovf_clr_i (ovf_clr_i),
    .irq_o     (irq_o),
    .full_o    (full_o),
    .rd_stb_i  (rd_stb_i),
    .byte_seen (byte_seen)
);

// File: tb/test_i2c_rx_slave.sv
module test_i2c_rx_slave;
    localparam int CLK_P = 10;
    localparam int Q     = 4;
    localparam logic [6:0] MY_ADDR = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       rd_stb = 1'b0, ovf_clr = 1'b0;
    logic       sda_oe, irq, full, ovf, rnw, dna;
    logic [7:0] rd_data;
    logic       sda_line;

    int n_chk = 0, n_bad = 0, irq_cnt = 0;

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_P/2) clk = ~clk;

    i2c_rx_slave i_i2c_rx_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .own_addr_i(MY_ADDR), .rd_stb_i(rd_stb),
        .rd_data_o(rd_data), .ovf_clr_i(ovf_clr), .irq_o(irq),
        .full_o(full), .ovf_o(ovf), .rnw_o(rnw), .data_nadr_o(dna)
    );

    always @(posedge clk) if (irq) irq_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_scl = 1'b0; m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        m_scl = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(2*Q);
            m_scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        acked = (sda_line == 1'b0);
        wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic cpu_read();
        rd_stb = 1'b1; wq(1);
        rd_stb = 1'b0; wq(1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic ack;
        int   base;
        wq(4);
        chk("R1 full", full, 0); chk("R1 ovf", ovf, 0);
        chk("R1 irq", irq, 0);   chk("R1 oe", sda_oe, 0);
        rst_n = 1'b1; wq(4);

        // R3 R4 R5: sweep all addresses, write direction
        for (int a = 0; a < 128; a++) begin
            base = irq_cnt;
            bus_start();
            send_byte({a[6:0], 1'b0}, ack);
            bus_stop();
            if (a[6:0] == MY_ADDR) begin
                chk("R3 ack on hit", ack, 1);
                chk("R4 buffer", rd_data, {a[6:0], 1'b0});
                chk("R4 full", full, 1);
                chk("R4 data_nadr", dna, 0);
                chk("R4 rnw", rnw, 0);
                chk("R7 irq count", irq_cnt - base, 1);
                cpu_read();
                chk("R9 full cleared", full, 0);
            end else begin
                chk("R5 nack on miss", ack, 0);
                chk("R5 no irq", irq_cnt - base, 0);
                chk("R5 buffer empty", full, 0);
            end
        end

        // R6 R7 R10: every data value in one transfer
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        cpu_read();
        for (int d = 0; d < 256; d++) begin
            base = irq_cnt;
            send_byte(d[7:0], ack);
            chk("R6 ack", ack, 1);
            chk("R6 data", rd_data, d);
            chk("R6 data_nadr", dna, 1);
            chk("R6 full", full, 1);
            chk("R7 one irq", irq_cnt - base, 1);
            chk("R10 released", sda_oe, 0);
            cpu_read();
            chk("R9 read clears", full, 0);
        end
        bus_stop();

        // R8 R9: overflow on a data byte while the address is unread
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        base = irq_cnt;
        send_byte(8'h5C, ack);
        chk("R8 nack", ack, 0);
        chk("R8 ovf", ovf, 1);
        chk("R8 kept", rd_data, {MY_ADDR, 1'b0});
        chk("R8 kept kind", dna, 0);
        chk("R7 irq on ovf", irq_cnt - base, 1);
        send_byte(8'h11, ack);
        chk("R8 nack again", ack, 0);
        chk("R9 ovf sticky", ovf, 1);
        ovf_clr = 1'b1; wq(1); ovf_clr = 1'b0; wq(1);
        chk("R9 ovf cleared", ovf, 0);
        cpu_read();
        send_byte(8'h33, ack);
        chk("R6 ack after read", ack, 1);
        chk("R6 data after read", rd_data, 8'h33);
        bus_stop();

        // R8: overflow on an address byte
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        chk("R8 addr ovf nack", ack, 0);
        chk("R8 addr ovf", ovf, 1);
        chk("R8 addr kept", rd_data, 8'h33);
        bus_stop();
        ovf_clr = 1'b1; wq(1); ovf_clr = 1'b0; wq(1);
        cpu_read();

        // R5: data after a missed address ignored
        bus_start();
        send_byte(8'h2A, ack);
        base = irq_cnt;
        send_byte(8'hAA, ack);
        chk("R5 data ignored", ack, 0);
        chk("R5 no irq", irq_cnt - base, 0);
        chk("R5 full", full, 0);
        bus_stop();

        // R2: byte clocked after a stop without a start
        base = irq_cnt;
        send_byte({MY_ADDR, 1'b0}, ack);
        chk("R2 no ack idle", ack, 0);
        chk("R2 no irq idle", irq_cnt - base, 0);
        chk("R2 full idle", full, 0);

        // R11 R12: repeated start to a read-direction address
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        cpu_read();
        send_byte(8'h01, ack);
        chk("R6 pre-restart", ack, 1);
        cpu_read();
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        chk("R11 restart ack", ack, 1);
        chk("R12 rnw", rnw, 1);
        chk("R12 addr kind", dna, 0);
        chk("R12 buffer", rd_data, {MY_ADDR, 1'b1});
        cpu_read();
        base = irq_cnt;
        send_byte(8'h77, ack);
        chk("R12 skip ack", ack, 0);
        chk("R12 skip irq", irq_cnt - base, 0);
        chk("R12 skip full", full, 0);
        bus_stop();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule